// File: doc/BRIEF.md
# Flash Command Decoder and Status Register

This block sits between a host write/read bus and the program/erase engine of a block-erasable flash array. Command codes arrive as byte writes. Some act in a single cycle and pick the read source: array, identifier, query or status. Others open a two-cycle sequence that must be closed by the correct second write. That write is a confirm code, a program address/data pair, a lock action or a ready-pin setting. Once a sequence is accepted it launches an operation that runs for a parameterised number of cycles per block.

The block keeps an 8-bit status register. Bit 7 is ready. Bits 5, 4, 3 and 1 are sticky error flags, whose pattern records why an operation was refused or failed. The block also keeps one lock bit and one erase-incomplete bit per block. A write-protect pin decides whether locked blocks may be changed. A supply-low input stands in for supply lockout detection. A small behavioural byte array lets program and erase results be observed. A ready output follows the engine in level mode, or gives a fixed-length low pulse on completion in one of three pulse modes.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After synchronous reset the read source is the array, every array byte reads FFh, the status reads 80h, no block is locked and `rdy_out` is high.
- R2: Writing FFh, 70h, 90h or 98h while idle selects the array, status, identifier or query source. In identifier mode, block offset 0 returns the maker code, offset 1 returns the device code, and offset 2 returns {6'b0, erase-incomplete, locked} of the addressed block. In query mode, offsets 0, 1 and 2 return 51h, 52h and 59h, and offset 3 returns 00h.
- R3: 20h followed by D0h erases the block of the second write's address to FFh. Status bit 7 stays low for exactly OP_CYC cycles. Reads then return status.
- R4: 40h or 10h followed by an address/data write stores (old AND data) at that address. Reads then return status.
- R5: A wrong second write after 20h, 30h or 60h, or a value above 03h after B8h, sets status bits 4 and 5 and starts nothing.
- R6: 50h clears status bits 5, 4, 3 and 1. While an operation runs, 50h has no effect.
- R7: With supply-low asserted, an erase sets bits 3 and 5 and marks the block erase-incomplete. A program or lock-set sets bits 3 and 4. Data is left unchanged.
- R8: 60h then 01h locks the addressed block when write-protect is high. When write-protect is low, that sequence sets bits 1 and 4. With write-protect low, a program on a locked block sets bits 1 and 4 and an erase sets bits 1 and 5, and data is unchanged. With write-protect high, a locked block is changed normally.
- R9: 60h then D0h clears every lock bit when write-protect is high. When write-protect is low it sets bits 1 and 5 and changes no lock.
- R10: 30h then D0h erases blocks 0 to 31 in ascending order. With write-protect low it skips locked blocks and raises no error. It stops at the first block whose erase fails, leaving later blocks unchanged.
- R11: While an operation runs, every write other than 70h is ignored. In particular FFh does not bring back array reads.
- R12: B8h then 00h/01h/02h/03h selects level mode (the default) or a pulse on erase, program, or both. Level mode drives `rdy_out` low while busy. In a pulse mode `rdy_out` stays high while busy and goes low for PULSE_CYC cycles after a matching operation ends.
- R13: In status mode, the value on `rd_data` is captured when `rd_strobe` rises and is held until the strobe has been low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle host write strobe |
| wr_addr | input | 7 | Write address {block, offset} |
| wr_data | input | 8 | Command or program data |
| rd_strobe | input | 1 | Host read strobe, active high |
| rd_addr | input | 7 | Read address {block, offset} |
| rd_data | output | 8 | Data from the selected read source |
| wprot_n | input | 1 | Write-protect, low protects locked blocks |
| supply_low | input | 1 | Program/erase supply below lockout |
| rdy_out | output | 1 | Ready indicator, level or pulse |

## Verification
The embedded properties watch on every cycle the invariants that span modules. A supply or protect flag never appears without an erase or program flag. A clear issued during busy never drops a sticky bit. Array reads cannot return while busy. The full-chip walk only ever advances by one block. A held status strobe keeps `rd_data` stable, and a pulse-mode low edge always follows a completion. Only the bench scenarios can show the effects on data and the lock state. These cover which bytes an erase or program really changed, skipping a locked block versus stopping on a failed block, the exact busy length, and the pulse width for each pulse configuration.

// File: rtl/flcmd_pkg.sv
package flcmd_pkg;

    localparam logic [7:0] CMD_RARR    = 8'hFF;
    localparam logic [7:0] CMD_RSTAT   = 8'h70;
    localparam logic [7:0] CMD_CLRS    = 8'h50;
    localparam logic [7:0] CMD_IDENT   = 8'h90;
    localparam logic [7:0] CMD_QUERY   = 8'h98;
    localparam logic [7:0] CMD_BERASE  = 8'h20;
    localparam logic [7:0] CMD_CERASE  = 8'h30;
    localparam logic [7:0] CMD_PROG    = 8'h40;
    localparam logic [7:0] CMD_PROG2   = 8'h10;
    localparam logic [7:0] CMD_LOCK    = 8'h60;
    localparam logic [7:0] CMD_CFG     = 8'hB8;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_LSET    = 8'h01;

    localparam int SB_READY  = 7;
    localparam int SB_ERASE  = 5;
    localparam int SB_PROG   = 4;
    localparam int SB_SUPPLY = 3;
    localparam int SB_PROT   = 1;

    typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_IDENT, RM_QUERY} rmode_e;

    typedef enum logic [2:0] {
        OP_NONE, OP_BERASE, OP_CERASE, OP_PROG, OP_LSET, OP_LCLR
    } eop_e;

    typedef enum logic [2:0] {
        DS_IDLE, DS_BERASE, DS_CERASE, DS_PROG, DS_LOCK, DS_CFG
    } dstate_e;

    function automatic logic is_erase(eop_e op);
        return (op == OP_BERASE) || (op == OP_CERASE);
    endfunction

    function automatic logic [7:0] err_bits(int a, int b);
        logic [7:0] v;
        v = '0;
        v[a] = 1'b1;
        v[b] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/flcmd_decode.sv
module flcmd_decode
    import flcmd_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              busy,
    output rmode_e            rmode,
    output logic              go,
    output eop_e              go_op,
    output logic [ADDR_W-1:0] go_addr,
    output logic [7:0]        go_data,
    output logic              clr_stat,
    output logic              bad_cfm,
    output logic [1:0]        rdy_cfg
);

    dstate_e    st, st_n;
    rmode_e     mode_n;
    logic [1:0] cfg_n;

    assign go_addr = wr_addr;
    assign go_data = wr_data;

    always_comb begin
        st_n     = st;
        mode_n   = rmode;
        cfg_n    = rdy_cfg;
        go       = 1'b0;
        go_op    = OP_NONE;
        clr_stat = 1'b0;
        bad_cfm  = 1'b0;
        if (wr_en) begin
            if (busy) begin
                if (wr_data == CMD_RSTAT) mode_n = RM_STATUS;
            end else begin
                unique case (st)
                    DS_IDLE: begin
                        unique case (wr_data)
                            CMD_RARR:  mode_n = RM_ARRAY;
                            CMD_RSTAT: mode_n = RM_STATUS;
                            CMD_IDENT: mode_n = RM_IDENT;
                            CMD_QUERY: mode_n = RM_QUERY;
                            CMD_CLRS:  clr_stat = 1'b1;
                            CMD_BERASE: begin st_n = DS_BERASE; mode_n = RM_STATUS; end
                            CMD_CERASE: begin st_n = DS_CERASE; mode_n = RM_STATUS; end
                            CMD_PROG, CMD_PROG2: begin st_n = DS_PROG; mode_n = RM_STATUS; end
                            CMD_LOCK:  begin st_n = DS_LOCK; mode_n = RM_STATUS; end
                            CMD_CFG:   st_n = DS_CFG;
                            default: ;
                        endcase
                    end
                    DS_BERASE, DS_CERASE: begin
                        st_n = DS_IDLE;
                        if (wr_data == CMD_CONFIRM) begin
                            go    = 1'b1;
                            go_op = (st == DS_BERASE) ? OP_BERASE : OP_CERASE;
                        end else begin
                            bad_cfm = 1'b1;
                        end
                    end
                    DS_PROG: begin
                        st_n  = DS_IDLE;
                        go    = 1'b1;
                        go_op = OP_PROG;
                    end
                    DS_LOCK: begin
                        st_n = DS_IDLE;
                        if (wr_data == CMD_LSET) begin
                            go = 1'b1; go_op = OP_LSET;
                        end else if (wr_data == CMD_CONFIRM) begin
                            go = 1'b1; go_op = OP_LCLR;
                        end else begin
                            bad_cfm = 1'b1;
                        end
                    end
                    DS_CFG: begin
                        st_n = DS_IDLE;
                        if (wr_data[7:2] == 6'd0) cfg_n = wr_data[1:0];
                        else                      bad_cfm = 1'b1;
                    end
                    default: st_n = DS_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= DS_IDLE;
            rmode   <= RM_ARRAY;
            rdy_cfg <= 2'd0;
        end else begin
            st      <= st_n;
            rmode   <= mode_n;
            rdy_cfg <= cfg_n;
        end
    end

    AST_NO_ARRAY_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && rmode != RM_ARRAY) |=> (rmode != RM_ARRAY)); // R11

endmodule

// File: rtl/flcmd_engine.sv
module flcmd_engine
    import flcmd_pkg::*;
#(
    parameter int NBLK   = 32,
    parameter int OFS_W  = 2,
    parameter int OP_CYC = 4,
    localparam int BLK_W  = $clog2(NBLK),
    localparam int ADDR_W = BLK_W + OFS_W,
    localparam int CNT_W  = $clog2(OP_CYC) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  eop_e              go_op,
    input  logic [ADDR_W-1:0] go_addr,
    input  logic [7:0]        go_data,
    input  logic              supply_low,
    input  logic              wprot_n,
    output logic              busy,
    output logic              done,
    output eop_e              done_op,
    output logic [7:0]        err_set,
    output logic [NBLK-1:0]   locks,
    output logic [NBLK-1:0]   ers_bad,
    output logic              ers_en,
    output logic [BLK_W-1:0]  ers_blk,
    output logic              pw_en,
    output logic [ADDR_W-1:0] pw_addr,
    output logic [7:0]        pw_data
);

    eop_e             op;
    logic [BLK_W-1:0] blk;
    logic [OFS_W-1:0] ofs;
    logic [7:0]       dat;
    logic [CNT_W-1:0] cnt;
    logic step, finish, adv, guard, lk_set, lk_clr, eb_set, eb_clr;

    assign step    = busy && (cnt == '0);
    assign guard   = locks[blk] && !wprot_n;
    assign ers_blk = blk;
    assign pw_addr = {blk, ofs};
    assign pw_data = dat;

    always_comb begin
        err_set = '0;
        ers_en  = 1'b0;
        pw_en   = 1'b0;
        finish  = 1'b0;
        adv     = 1'b0;
        lk_set  = 1'b0;
        lk_clr  = 1'b0;
        eb_set  = 1'b0;
        eb_clr  = 1'b0;
        if (step) begin
            unique case (op)
                OP_BERASE: begin
                    finish = 1'b1;
                    if (supply_low) begin
                        err_set = err_bits(SB_SUPPLY, SB_ERASE);
                        eb_set  = 1'b1;
                    end else if (guard) begin
                        err_set = err_bits(SB_PROT, SB_ERASE);
                    end else begin
                        ers_en = 1'b1;
                        eb_clr = 1'b1;
                    end
                end
                OP_CERASE: begin
                    if (supply_low) begin
                        err_set = err_bits(SB_SUPPLY, SB_ERASE);
                        eb_set  = 1'b1;
                        finish  = 1'b1;
                    end else begin
                        if (!guard) begin
                            ers_en = 1'b1;
                            eb_clr = 1'b1;
                        end
                        if (blk == BLK_W'(NBLK - 1)) finish = 1'b1;
                        else                         adv    = 1'b1;
                    end
                end
                OP_PROG: begin
                    finish = 1'b1;
                    if (supply_low) err_set = err_bits(SB_SUPPLY, SB_PROG);
                    else if (guard) err_set = err_bits(SB_PROT, SB_PROG);
                    else            pw_en   = 1'b1;
                end
                OP_LSET: begin
                    finish = 1'b1;
                    if (supply_low)    err_set = err_bits(SB_SUPPLY, SB_PROG);
                    else if (!wprot_n) err_set = err_bits(SB_PROT, SB_PROG);
                    else               lk_set  = 1'b1;
                end
                OP_LCLR: begin
                    finish = 1'b1;
                    if (supply_low)    err_set = err_bits(SB_SUPPLY, SB_ERASE);
                    else if (!wprot_n) err_set = err_bits(SB_PROT, SB_ERASE);
                    else               lk_clr  = 1'b1;
                end
                default: finish = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            done_op <= OP_NONE;
            op      <= OP_NONE;
            blk     <= '0;
            ofs     <= '0;
            dat     <= '0;
            cnt     <= '0;
            locks   <= '0;
            ers_bad <= '0;
        end else begin
            done <= 1'b0;
            if (go && !busy) begin
                busy <= 1'b1;
                op   <= go_op;
                blk  <= (go_op == OP_CERASE) ? '0 : go_addr[ADDR_W-1:OFS_W];
                ofs  <= go_addr[OFS_W-1:0];
                dat  <= go_data;
                cnt  <= CNT_W'(OP_CYC - 1);
            end else if (busy) begin
                if (step) begin
                    if (finish) begin
                        busy    <= 1'b0;
                        done    <= 1'b1;
                        done_op <= op;
                    end
                    if (adv) begin
                        blk <= blk + 1'b1;
                        cnt <= CNT_W'(OP_CYC - 1);
                    end
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
            if (lk_set) locks[blk]   <= 1'b1;
            if (lk_clr) locks        <= '0;
            if (eb_set) ers_bad[blk] <= 1'b1;
            if (eb_clr) ers_bad[blk] <= 1'b0;
        end
    end

    AST_CHIP_WALK: assert property (@(posedge clk) disable iff (rst)
        (busy && op == OP_CERASE && $past(busy && op == OP_CERASE) && blk != $past(blk))
        |-> (blk == $past(blk) + 1'b1)); // R10

endmodule

// File: rtl/flcmd_array.sv
module flcmd_array #(
    parameter int NBLK  = 32,
    parameter int OFS_W = 2,
    localparam int BLK_W  = $clog2(NBLK),
    localparam int ADDR_W = BLK_W + OFS_W,
    localparam int WPB    = 1 << OFS_W,
    localparam int DEPTH  = NBLK * WPB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ers_en,
    input  logic [BLK_W-1:0]  ers_blk,
    input  logic              pw_en,
    input  logic [ADDR_W-1:0] pw_addr,
    input  logic [7:0]        pw_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    logic [7:0] mem [DEPTH];

    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else begin
            if (ers_en) begin
                for (int i = 0; i < WPB; i++) mem[{ers_blk, OFS_W'(i)}] <= 8'hFF;
            end
            if (pw_en) mem[pw_addr] <= mem[pw_addr] & pw_data;
        end
    end

endmodule

// File: rtl/flcmd_rdy.sv
module flcmd_rdy
    import flcmd_pkg::*;
#(
    parameter int PULSE_CYC = 3,
    localparam int PW = $clog2(PULSE_CYC + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] rdy_cfg,
    input  logic       busy,
    input  logic       done,
    input  eop_e       done_op,
    output logic       rdy_out
);

    logic [PW-1:0] cnt;
    logic          hit;

    assign hit = done && ((rdy_cfg[0] && is_erase(done_op)) ||
                          (rdy_cfg[1] && done_op == OP_PROG));

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (hit)        cnt <= PW'(PULSE_CYC);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign rdy_out = (rdy_cfg == 2'd0) ? !busy : (cnt == '0);

    AST_PULSE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        (rdy_cfg != 2'd0 && $fell(rdy_out)) |-> $past(done)); // R12

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flcmd_pkg::*;
#(
    parameter int         NBLK      = 32,
    parameter int         OFS_W     = 2,
    parameter int         OP_CYC    = 4,
    parameter int         PULSE_CYC = 3,
    parameter logic [7:0] MFR_CODE  = 8'hA5,
    parameter logic [7:0] DEV_CODE  = 8'h3C,
    localparam int BLK_W  = $clog2(NBLK),
    localparam int ADDR_W = BLK_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              rd_strobe,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              wprot_n,
    input  logic              supply_low,
    output logic              rdy_out
);

    rmode_e            rmode;
    eop_e              go_op, done_op;
    logic              go, clr_stat, bad_cfm, busy, done;
    logic [ADDR_W-1:0] go_addr;
    logic [7:0]        go_data, err_set, stk, status, snap, arr_q;
    logic [1:0]        rdy_cfg;
    logic [NBLK-1:0]   locks, ers_bad;
    logic              ers_en, pw_en, rd_q;
    logic [BLK_W-1:0]  ers_blk, rblk;
    logic [ADDR_W-1:0] pw_addr;
    logic [7:0]        pw_data;

    flcmd_decode #(.ADDR_W(ADDR_W)) i_dec (
        .clk, .rst, .wr_en, .wr_addr, .wr_data, .busy,
        .rmode, .go, .go_op, .go_addr, .go_data, .clr_stat, .bad_cfm, .rdy_cfg
    );

    flcmd_engine #(.NBLK(NBLK), .OFS_W(OFS_W), .OP_CYC(OP_CYC)) i_eng (
        .clk, .rst, .go, .go_op, .go_addr, .go_data, .supply_low, .wprot_n,
        .busy, .done, .done_op, .err_set, .locks, .ers_bad,
        .ers_en, .ers_blk, .pw_en, .pw_addr, .pw_data
    );

    flcmd_array #(.NBLK(NBLK), .OFS_W(OFS_W)) i_arr (
        .clk, .rst, .ers_en, .ers_blk, .pw_en, .pw_addr, .pw_data,
        .rd_addr, .rd_data(arr_q)
    );

    flcmd_rdy #(.PULSE_CYC(PULSE_CYC)) i_rdy (
        .clk, .rst, .rdy_cfg, .busy, .done, .done_op, .rdy_out
    );

    // Sticky error flags; bit 7 is derived live from the engine.
    always_ff @(posedge clk) begin
        if (rst)           stk <= '0;
        else if (clr_stat) stk <= '0;
        else               stk <= stk | err_set | (bad_cfm ? err_bits(SB_PROG, SB_ERASE) : 8'h00);
    end

    always_comb begin
        status = 8'h00;
        status[SB_READY]  = !busy;
        status[SB_ERASE]  = stk[SB_ERASE];
        status[SB_PROG]   = stk[SB_PROG];
        status[SB_SUPPLY] = stk[SB_SUPPLY];
        status[SB_PROT]   = stk[SB_PROT];
    end

    // Status snapshot taken on the strobe's active edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= 1'b0;
            snap <= 8'h80;
        end else begin
            rd_q <= rd_strobe;
            if (rd_strobe && !rd_q) snap <= status;
        end
    end

    assign rblk = rd_addr[ADDR_W-1:OFS_W];

    always_comb begin
        unique case (rmode)
            RM_ARRAY:  rd_data = arr_q;
            RM_STATUS: rd_data = (rd_strobe && rd_q) ? snap : status;
            RM_IDENT: begin
                unique case (rd_addr[1:0])
                    2'd0:    rd_data = MFR_CODE;
                    2'd1:    rd_data = DEV_CODE;
                    2'd2:    rd_data = {6'd0, ers_bad[rblk], locks[rblk]};
                    default: rd_data = 8'h00;
                endcase
            end
            default: begin
                unique case (rd_addr[1:0])
                    2'd0:    rd_data = 8'h51;
                    2'd1:    rd_data = 8'h52;
                    2'd2:    rd_data = 8'h59;
                    default: rd_data = 8'h00;
                endcase
            end
        endcase
    end

    AST_ERR_CAUSE_PAIRED: assert property (@(posedge clk) disable iff (rst)
        (status[SB_SUPPLY] || status[SB_PROT]) |-> (status[SB_ERASE] || status[SB_PROG])); // R7

    AST_CLEAR_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en && wr_data == CMD_CLRS) |=> ((stk & $past(stk)) == $past(stk))); // R6

    AST_STATUS_HELD: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && rd_q && rmode == RM_STATUS &&
         $past(rd_strobe && rd_q && rmode == RM_STATUS)) |-> $stable(rd_data)); // R13

endmodule

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;

    localparam int OP_CYC    = 4;
    localparam int PULSE_CYC = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [6:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_strobe = 1'b0;
    logic [6:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       wprot_n = 1'b1;
    logic       supply_low = 1'b0;
    logic       rdy_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    flash_cmd_ctrl #(.OP_CYC(OP_CYC), .PULSE_CYC(PULSE_CYC)) i_flash_cmd_ctrl (
        .clk, .rst, .wr_en, .wr_addr, .wr_data, .rd_strobe, .rd_addr,
        .rd_data, .wprot_n, .supply_low, .rdy_out
    );

    // Vector: rd=1 read and compare with d, rd=0 write d; req tags in comments.
    typedef struct packed {
        logic       rd;
        logic [3:0] req;
        logic [6:0] a;
        logic [7:0] d;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VT [NV] = '{
        '{1'b1, 4'd1, 7'h00, 8'hFF},  // R1 array after reset
        '{1'b1, 4'd1, 7'h7F, 8'hFF},  // R1
        '{1'b0, 4'd2, 7'h00, 8'h70},  // R2 status source
        '{1'b1, 4'd2, 7'h00, 8'h80},
        '{1'b0, 4'd2, 7'h00, 8'h90},  // R2 identifier source
        '{1'b1, 4'd2, 7'h00, 8'hA5},
        '{1'b1, 4'd2, 7'h15, 8'h3C},
        '{1'b1, 4'd2, 7'h16, 8'h00},
        '{1'b0, 4'd2, 7'h00, 8'h98},  // R2 query source
        '{1'b1, 4'd2, 7'h00, 8'h51},
        '{1'b1, 4'd2, 7'h01, 8'h52},
        '{1'b1, 4'd2, 7'h02, 8'h59},
        '{1'b1, 4'd2, 7'h03, 8'h00},
        '{1'b0, 4'd4, 7'h06, 8'h40},  // R4 program with 40h
        '{1'b0, 4'd4, 7'h06, 8'h3C},
        '{1'b1, 4'd4, 7'h00, 8'h80},
        '{1'b0, 4'd4, 7'h00, 8'hFF},
        '{1'b1, 4'd4, 7'h06, 8'h3C},
        '{1'b0, 4'd4, 7'h06, 8'h10},  // R4 program with 10h, AND of data
        '{1'b0, 4'd4, 7'h06, 8'hF0},
        '{1'b0, 4'd3, 7'h04, 8'h20},  // R3 block erase
        '{1'b0, 4'd3, 7'h04, 8'hD0},
        '{1'b0, 4'd3, 7'h00, 8'hFF},
        '{1'b1, 4'd3, 7'h06, 8'hFF}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] v);
        rd_addr = a; rd_strobe = 1'b1;
        #1 v = rd_data;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 1000 && !rdy_out; g++) @(negedge clk);
    endtask

    task automatic cmd2(input logic [6:0] a, input logic [7:0] c1, input logic [7:0] c2);
        wr(a, c1);
        wr(a, c2);
        wait_idle();
    endtask

    task automatic count_low(input int n, output int lows);
        lows = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!rdy_out) lows++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v, v2;
        int lows;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready pin after reset", {7'd0, rdy_out}, 8'h01);

        for (int i = 0; i < NV; i++) begin
            if (VT[i].rd) begin
                rd(VT[i].a, v);
                chk($sformatf("R%0d table[%0d]", VT[i].req, i), v, VT[i].d);
            end else begin
                wr(VT[i].a, VT[i].d);
                wait_idle();
            end
        end

        // R3 busy length: status bit 7 low for OP_CYC cycles
        wr(7'h08, 8'h20);
        wr(7'h08, 8'hD0);
        lows = 1;
        for (int i = 0; i < 50 && !rdy_out; i++) begin @(negedge clk); if (!rdy_out) lows++; end
        chk("R3 busy cycles", 8'(lows), 8'(OP_CYC));

        // R5 bad confirm: no erase, bits 4 and 5
        cmd2(7'h09, 8'h40, 8'h0F);
        cmd2(7'h08, 8'h20, 8'h55);
        rd(0, v); chk("R5 bad erase confirm status", v, 8'hB0);
        wr(0, 8'hFF); rd(7'h09, v); chk("R5 block untouched", v, 8'h0F);
        wr(0, 8'h50); wr(0, 8'h70); rd(0, v); chk("R6 clear sticky", v, 8'h80);
        cmd2(0, 8'h60, 8'h77);
        rd(0, v); chk("R5 bad lock confirm", v, 8'hB0);
        cmd2(0, 8'hB8, 8'h04);
        rd(0, v); chk("R5 bad ready config", v, 8'hB0);

        // R6 clear ignored while busy
        wr(0, 8'h30); wr(0, 8'hD0);
        wr(0, 8'h50);
        wait_idle();
        rd(0, v); chk("R6 clear while busy ignored", v, 8'hB0);
        wr(0, 8'h50); wr(0, 8'h70); rd(0, v); chk("R6 clear idle", v, 8'h80);

        // R7 supply low
        cmd2(7'h08, 8'h40, 8'h11);
        supply_low = 1'b1;
        cmd2(7'h08, 8'h20, 8'hD0);
        rd(0, v); chk("R7 erase supply low", v, 8'hA8);
        wr(0, 8'h90); rd(7'h0A, v); chk("R7 erase-incomplete flag", v, 8'h02);
        wr(0, 8'hFF); rd(7'h08, v); chk("R7 data kept", v, 8'h11);
        wr(0, 8'h50);
        cmd2(7'h08, 8'h40, 8'h00);
        rd(0, v); chk("R7 program supply low", v, 8'h98);
        wr(0, 8'h50);
        supply_low = 1'b0;

        // R8 lock set and protection
        cmd2(7'h0C, 8'h40, 8'h5A);
        cmd2(7'h0C, 8'h60, 8'h01);
        rd(0, v); chk("R8 lock set status", v, 8'h80);
        wr(0, 8'h90); rd(7'h0E, v); chk("R8 lock bit visible", v, 8'h01);
        wprot_n = 1'b0;
        cmd2(7'h0C, 8'h40, 8'h00);
        rd(0, v); chk("R8 program locked wp low", v, 8'h92);
        wr(0, 8'h50);
        cmd2(7'h0C, 8'h20, 8'hD0);
        rd(0, v); chk("R8 erase locked wp low", v, 8'hA2);
        wr(0, 8'hFF); rd(7'h0C, v); chk("R8 locked data kept", v, 8'h5A);
        wr(0, 8'h50);
        cmd2(7'h10, 8'h60, 8'h01);
        rd(0, v); chk("R8 lock set wp low", v, 8'h92);
        wr(0, 8'h50);
        wprot_n = 1'b1;
        cmd2(7'h0D, 8'h40, 8'h66);
        wr(0, 8'hFF); rd(7'h0D, v); chk("R8 locked block wp high", v, 8'h66);

        // R10 chip erase skips locked block with wp low
        cmd2(7'h10, 8'h40, 8'h22);
        wprot_n = 1'b0;
        cmd2(0, 8'h30, 8'hD0);
        rd(0, v); chk("R10 skip raises no error", v, 8'h80);
        wr(0, 8'hFF); rd(7'h0C, v); chk("R10 locked block skipped", v, 8'h5A);
        rd(7'h10, v); chk("R10 next block erased", v, 8'hFF);
        wr(0, 8'h90); rd(7'h0A, v); chk("R10 erase flag cleared", v, 8'h00);
        wprot_n = 1'b1;

        // R10 stop at first failing block
        cmd2(7'h08, 8'h40, 8'h33);
        cmd2(7'h50, 8'h40, 8'h44);
        wr(0, 8'h30); wr(0, 8'hD0);
        repeat (10 * OP_CYC) @(negedge clk);
        supply_low = 1'b1;
        wait_idle();
        supply_low = 1'b0;
        rd(0, v); chk("R10 stop status", v, 8'hA8);
        wr(0, 8'hFF); rd(7'h08, v); chk("R10 early block erased", v, 8'hFF);
        rd(7'h50, v); chk("R10 late block untouched", v, 8'h44);
        wr(0, 8'h90); rd(7'h7E, v); chk("R10 last block not reached", v, 8'h00);
        wr(0, 8'h50);

        // R9 clear all locks
        wprot_n = 1'b0;
        cmd2(0, 8'h60, 8'hD0);
        rd(0, v); chk("R9 clear wp low status", v, 8'hA2);
        wr(0, 8'h90); rd(7'h0E, v); chk("R9 lock kept", v, 8'h01);
        wr(0, 8'h50);
        wprot_n = 1'b1;
        cmd2(0, 8'h60, 8'hD0);
        wr(0, 8'h90); rd(7'h0E, v); chk("R9 lock cleared", v, 8'h00);

        // R11 writes ignored while busy
        wr(0, 8'h30); wr(0, 8'hD0);
        wr(0, 8'hFF);
        wr(0, 8'h90);
        rd(0, v); chk("R11 status while busy", v, 8'h00);
        wait_idle();
        rd(0, v); chk("R11 read array refused while busy", v, 8'h80);

        // R13 status held while strobe stays high
        wr(0, 8'h30); wr(0, 8'hD0);
        @(negedge clk);
        rd_strobe = 1'b1;
        #1 v = rd_data;
        repeat (200) @(negedge clk);
        #1 v2 = rd_data;
        chk("R13 held value", v2, v);
        chk("R13 captured while busy", v2, 8'h00);
        rd_strobe = 1'b0;
        @(negedge clk);
        rd(0, v); chk("R13 refreshed after strobe low", v, 8'h80);

        // R12 ready pin configurations
        cmd2(0, 8'hB8, 8'h01);
        wr(7'h20, 8'h20); wr(7'h20, 8'hD0);
        chk("R12 pulse mode high while busy", {7'd0, rdy_out}, 8'h01);
        count_low(30, lows);
        chk("R12 erase pulse width", 8'(lows), 8'(PULSE_CYC));
        cmd2(0, 8'hB8, 8'h02);
        wr(7'h20, 8'h20); wr(7'h20, 8'hD0);
        count_low(30, lows);
        chk("R12 no pulse for erase in program mode", 8'(lows), 8'h00);
        wr(7'h20, 8'h40); wr(7'h20, 8'h12);
        count_low(30, lows);
        chk("R12 program pulse width", 8'(lows), 8'(PULSE_CYC));
        cmd2(0, 8'hB8, 8'h00);
        wr(7'h20, 8'h20); wr(7'h20, 8'hD0);
        chk("R12 level mode low while busy", {7'd0, rdy_out}, 8'h00);
        wait_idle();

        // R1 reset restores state
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd(7'h21, v); chk("R1 array after reset", v, 8'hFF);
        wr(0, 8'h70); rd(0, v); chk("R1 status after reset", v, 8'h80);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule